// File: doc/BRIEF.md
# Dual-Bank FSK/PSK Numerically Controlled Oscillator

This block is a numerically controlled oscillator with two frequency tuning words and two phase offset words. All of them are loaded through a framed 16-bit serial write port. The phase accumulator adds the active tuning word on every system clock. One select bit picks which tuning word is active, so toggling it switches the carrier between a mark frequency and a space frequency (FSK). A second select bit picks which phase offset is added to the top of the accumulator, which shifts the carrier phase (PSK).

The outputs are a 12-bit phase word, meant for an external sine lookup or DAC path, and a square wave taken from the MSB of that word. A host writes words by pulling the frame line low and clocking in 16 bits. Each bit is captured on a falling serial clock edge, MSB first. A completed word crosses into the system clock domain through a two-flop synchroniser on a toggle strobe. It is then decoded by its top two address bits.

Top module: `fsk_psk_nco`

## Requirements
- R1: After the asynchronous reset `rst_ni` the outputs read `phase_o` = 0 and `square_o` = 0. All tuning words, offsets and control bits are cleared at the same reset.
- R2: A serial word is the 16 values of `sdata_i` sampled on falling `sclk_i` edges while `fsync_i` is low, MSB first. Bits [15:14] are the address: 00 control, 01 tuning word 0, 10 tuning word 1, 11 phase offset.
- R3: If `fsync_i` rises before the 16th bit, the partial word is dropped and no register changes. The next frame starts again at bit 15.
- R4: Falling `sclk_i` edges while `fsync_i` is high have no effect. A word may be sent as two 8-bit bursts with `fsync_i` held low and `sclk_i` idle, high or low, between the bursts.
- R5: A tuning word write loads its bits [13:0] into the low half [13:0] of the 28-bit register when control bit 3 is 0, and into the high half [27:14] when it is 1. The other half is kept. Registers change only on a decoded write.
- R6: A phase write loads bits [11:0] into offset 0 when bit 13 is 0 and into offset 1 when bit 13 is 1. Control bit 2 selects the offset that is applied.
- R7: Control bit 0 holds the accumulator at zero while it is set. Meanwhile `phase_o` equals the selected offset.
- R8: Control bit 1 selects tuning word 1 (1) or tuning word 0 (0). While it is running, `phase_o` advances each system clock by accumulator bits [27:16] of that word, modulo 4096, with a carry from the lower bits.
- R9: `square_o` always equals bit 11 of `phase_o`.
- R10: `phase_o` is the registered sum, modulo 4096, of accumulator bits [27:16] and the selected 12-bit offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, data captured on falling edge |
| fsync_i | input | 1 | Active-low frame for a 16-bit serial word |
| sdata_i | input | 1 | Serial data, MSB first |
| phase_o | output | 12 | Truncated phase word with offset |
| square_o | output | 1 | Square wave from the phase MSB |

## Verification
A bit counter that is off by one in the serial domain shows up on the first completed frame. The assembled word then lands in the wrong register or carries a shifted value, and this is visible on `phase_o` about four system clocks after the frame ends. With the accumulator held, a wrong offset or select decode appears as a wrong static `phase_o`. A wrong tuning word or half-select appears as a wrong per-clock phase step within two samples of release.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int ACC_W  = 28;
  localparam int PH_W   = 12;
  localparam int WORD_W = 16;
  localparam int NBANK  = 2;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'b00,
    ADDR_F0   = 2'b01,
    ADDR_F1   = 2'b10,
    ADDR_PH   = 2'b11
  } addr_e;

  // control word bit positions
  localparam int CTL_CLR  = 0;
  localparam int CTL_FSEL = 1;
  localparam int CTL_PSEL = 2;
  localparam int CTL_HI   = 3;
  localparam int PH_BANK  = 13;
endpackage

// File: rtl/nco_serial_rx.sv
module nco_serial_rx #(
  parameter int W  = nco_pkg::WORD_W,
  localparam int CW = $clog2(W)
) (
  input  logic         rst_ni,
  input  logic         sclk_i,
  input  logic         fsync_i,
  input  logic         sdata_i,
  output logic [W-1:0] word_o,
  output logic         tgl_o
);
  logic [CW-1:0] cnt_q;
  logic [W-2:0]  sh_q;
  logic          last_bit;

  assign last_bit = (cnt_q == CW'(W-1));

  // frame high clears the bit count asynchronously; sclk may be idle
  always_ff @(negedge sclk_i or negedge rst_ni or posedge fsync_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (fsync_i) begin
      cnt_q <= '0;
    end else begin
      sh_q  <= {sh_q[W-3:0], sdata_i};
      cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(negedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0;
      tgl_o  <= 1'b0;
    end else if (!fsync_i && last_bit) begin
      word_o <= {sh_q, sdata_i};
      tgl_o  <= ~tgl_o;
    end
  end
endmodule

// File: rtl/nco_regs.sv
module nco_regs
  import nco_pkg::*;
#(
  parameter int AW = ACC_W,
  parameter int PW = PH_W,
  parameter int WW = WORD_W,
  parameter int NB = NBANK,
  localparam int HW = WW - 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [WW-1:0]        word_i,
  input  logic                 tgl_i,
  output logic [NB-1:0][AW-1:0] freq_o,
  output logic [NB-1:0][PW-1:0] phase_o,
  output logic                 clr_o,
  output logic                 fsel_o,
  output logic                 psel_o,
  output logic                 upd_o
);
  logic [2:0] sync_q;
  logic [3:0] ctrl_q;
  addr_e      addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], tgl_i};
  end

  assign upd_o = sync_q[2] ^ sync_q[1];
  assign addr  = addr_e'(word_i[WW-1:WW-2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         ctrl_q <= '0;
    else if (upd_o && addr == ADDR_CTRL) ctrl_q <= word_i[3:0];
  end

  assign clr_o  = ctrl_q[CTL_CLR];
  assign fsel_o = ctrl_q[CTL_FSEL];
  assign psel_o = ctrl_q[CTL_PSEL];

  for (genvar i = 0; i < NB; i++) begin : g_bank
    localparam logic [1:0] FADDR = 2'(i + 1);
    logic [AW-1:0] f_q;
    logic [PW-1:0] p_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        f_q <= '0;
      end else if (upd_o && word_i[WW-1:WW-2] == FADDR) begin
        if (ctrl_q[CTL_HI]) f_q[AW-1:HW] <= word_i[HW-1:0];
        else                f_q[HW-1:0]  <= word_i[HW-1:0];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        p_q <= '0;
      else if (upd_o && addr == ADDR_PH && word_i[PH_BANK] == 1'(i))
        p_q <= word_i[PW-1:0];
    end

    assign freq_o[i]  = f_q;
    assign phase_o[i] = p_q;
  end
endmodule

// File: rtl/nco_core.sv
module nco_core #(
  parameter int AW = nco_pkg::ACC_W,
  parameter int PW = nco_pkg::PH_W,
  parameter int NB = nco_pkg::NBANK
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NB-1:0][AW-1:0] freq_i,
  input  logic [NB-1:0][PW-1:0] phase_i,
  input  logic                  clr_i,
  input  logic                  fsel_i,
  input  logic                  psel_i,
  output logic [PW-1:0]         phase_o,
  output logic                  square_o
);
  logic [AW-1:0] acc_q;
  logic [AW-1:0] f_act;
  logic [PW-1:0] poff;
  logic [PW-1:0] sum;

  assign f_act = freq_i[fsel_i];
  assign poff  = phase_i[psel_i];
  assign sum   = acc_q[AW-1:AW-PW] + poff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      phase_o  <= '0;
      square_o <= 1'b0;
    end else begin
      acc_q    <= clr_i ? '0 : acc_q + f_act;
      phase_o  <= sum;
      square_o <= sum[PW-1];
    end
  end
endmodule

// File: rtl/fsk_psk_nco.sv
module fsk_psk_nco
  import nco_pkg::*;
#(
  parameter int AW = ACC_W,
  parameter int PW = PH_W,
  parameter int WW = WORD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          fsync_i,
  input  logic          sdata_i,
  output logic [PW-1:0] phase_o,
  output logic          square_o
);
  logic [WW-1:0]            word_w;
  logic                     tgl_w;
  logic [NBANK-1:0][AW-1:0] freq_w;
  logic [NBANK-1:0][PW-1:0] phase_w;
  logic                     clr_w, fsel_w, psel_w, upd_w;

  nco_serial_rx #(.W(WW)) u_rx (
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .fsync_i(fsync_i),
    .sdata_i(sdata_i),
    .word_o (word_w),
    .tgl_o  (tgl_w)
  );

  nco_regs #(.AW(AW), .PW(PW), .WW(WW), .NB(NBANK)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .word_i (word_w),
    .tgl_i  (tgl_w),
    .freq_o (freq_w),
    .phase_o(phase_w),
    .clr_o  (clr_w),
    .fsel_o (fsel_w),
    .psel_o (psel_w),
    .upd_o  (upd_w)
  );

  nco_core #(.AW(AW), .PW(PW), .NB(NBANK)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .freq_i  (freq_w),
    .phase_i (phase_w),
    .clr_i   (clr_w),
    .fsel_i  (fsel_w),
    .psel_i  (psel_w),
    .phase_o (phase_o),
    .square_o(square_o)
  );
endmodule

// File: rtl/nco_chk.sv
module nco_chk #(
  parameter int AW = nco_pkg::ACC_W,
  parameter int PW = nco_pkg::PH_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [PW-1:0]      phase_o,
  input logic               square_o,
  input logic [1:0][AW-1:0] freq_i,
  input logic [1:0][PW-1:0] phase_i,
  input logic               clr_i,
  input logic               psel_i,
  input logic               upd_i
);
  logic [PW-1:0] exp_off;
  assign exp_off = psel_i ? phase_i[1] : phase_i[0];

  // R7
  clr_holds_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(clr_i) && clr_i) |=> (phase_o == $past(exp_off)));

  // R9
  square_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    square_o == phase_o[PW-1]);

  // R5
  freq_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(freq_i));

  // R6
  phase_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(phase_i));
endmodule

bind fsk_psk_nco nco_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .phase_o (phase_o),
  .square_o(square_o),
  .freq_i  (freq_w),
  .phase_i (phase_w),
  .clr_i   (clr_w),
  .psel_i  (psel_w),
  .upd_i   (upd_w)
);

// File: tb/fsk_psk_nco_tb_top.sv
`timescale 1ns/1ps
module fsk_psk_nco_tb_top;
  logic clk = 0, rst_ni = 0, sclk = 0, fsync = 1, sdata = 0;
  logic [11:0] phase;
  logic        square;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    int     kind;   // 0 static value, 1 exact step, 2 step range [exp, exp+1]
    int     exp;
    string  tag;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  fsk_psk_nco dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .fsync_i(fsync),
    .sdata_i(sdata), .phase_o(phase), .square_o(square)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items and compares against two consecutive samples
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        int s1, s2, d;
        it = q[0];
        s1 = phase;
        chk(square == phase[11], "R9 square", square, phase[11]);
        @(negedge clk);
        s2 = phase;
        d  = (s2 - s1) & 12'hfff;
        case (it.kind)
          0: begin
               chk(s1 == it.exp, it.tag, s1, it.exp);
               chk(s2 == it.exp, it.tag, s2, it.exp);
             end
          1: chk(d == it.exp, it.tag, d, it.exp);
          default: chk(d == it.exp || d == it.exp + 1, it.tag, d, it.exp);
        endcase
        void'(q.pop_front());
      end
    end
  end

  task automatic expect_item(input int kind, input int exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w, input bit idle_hi = 0,
                      input int gap = 0, input int nbits = 16);
    sclk = idle_hi;
    #20 fsync = 0;
    #20;
    for (int i = 0; i < nbits; i++) begin
      sclk = 1; sdata = w[15-i];
      #20 sclk = 0;
      #20;
      if (i == 7 && gap > 0) begin
        sclk = idle_hi;
        #(gap);
      end
    end
    sclk = idle_hi;
    #20 fsync = 1;
    repeat (25) @(negedge clk);
  endtask

  task automatic stray_edges();
    for (int i = 0; i < 5; i++) begin
      sclk = 1; sdata = 1;
      #20 sclk = 0;
      #20;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(phase == 0, "R1 phase reset", phase, 0);
    chk(square == 0, "R1 square reset", square, 0);
    rst_ni = 1;
    repeat (3) @(negedge clk);
    chk(phase == 0, "R1 idle after reset", phase, 0);

    send(16'h0001);                          // clear held
    send(16'hC123);                          // offset 0 = 0x123
    expect_item(0, 12'h123, "R2 R6 R7 offset0 static");
    send(16'hEABC);                          // offset 1 = 0xABC
    expect_item(0, 12'h123, "R6 offset1 write keeps psel0 output");
    send(16'h0005);                          // clear + psel
    expect_item(0, 12'hABC, "R6 R10 psel selects offset1");

    send(16'hE0FF, 0, 0, 8);                 // partial frame
    expect_item(0, 12'hABC, "R3 partial word dropped");
    send(16'hE555);
    expect_item(0, 12'h555, "R3 frame after partial realigned");

    send(16'hE3C3, 1, 300);                  // split bursts, idle high
    expect_item(0, 12'h3C3, "R4 split burst idle high");
    send(16'hE0F0, 0, 250);                  // split bursts, idle low
    expect_item(0, 12'h0F0, "R4 split burst idle low");
    stray_edges();
    repeat (5) @(negedge clk);
    expect_item(0, 12'h0F0, "R4 edges with frame high ignored");
    send(16'hE777);
    expect_item(0, 12'h777, "R4 word after stray edges aligned");

    send(16'h0009);                          // clear, high-half writes, psel0
    send(16'h4010);                          // tuning 0 = 0x40000
    send(16'h8080);                          // tuning 1 = 0x200000
    expect_item(0, 12'h123, "R7 clear holds offset0");
    send(16'h0008);                          // run on tuning 0
    expect_item(1, 4, "R8 R5 tuning0 step");
    send(16'h000A);                          // run on tuning 1
    expect_item(1, 12'h20, "R8 tuning1 step");
    send(16'h0000);                          // low-half writes, fsel0
    send(16'h7FFF);                          // tuning 0 = 0x43FFF
    expect_item(2, 4, "R5 low half write keeps high half");
    send(16'h0003);                          // clear with fsel1
    expect_item(0, 12'h123, "R7 clear while running");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule